// File: doc/BRIEF.md
# Remote-Request Auto-Response Buffer Controller

This block is the control state machine behind a single transmit message buffer on a CAN controller. The buffer holds a 4-bit code and is given an identifier. While the code is armed, the block watches every received frame. When a remote request frame carries the same identifier as the buffer, the block arms itself to send the matching data frame and raises a transmit request toward the shared arbitration logic. After that data frame goes out successfully, the code drops back to the armed value, so the buffer answers the next request with no software action.

Software steers the buffer through code writes. Writing the send code forces one unconditional transmission. Writing any other code takes over at once and withdraws any pending request. The arbiter grants the buffer a slot in a round. The transmit engine then reports success, or failure (lost arbitration or an error). After a failure the request is raised again for the next round. The receive port is a plain qualifier with no back-pressure: a frame is seen only in the cycle its valid is high, and the block never stalls it. Grant, completion and write strobes are single-cycle controls.

Code values: 1000 is inactive, 1010 is armed (wait for a remote request), 1110 is send-once. Any other written value is held with no automatic action.

Top module: `rrq_resp_ctrl`

## Requirements
- R1: After reset the code is 1000 and `tx_req` is low.
- R2: With the code at 1010, a received frame with valid and RTR set whose identifier and IDE match the buffer sets the code to 1110 on the next clock, and `tx_req` rises in that same cycle.
- R3: With IDE low, only identifier bits [10:0] are compared and bits [28:11] are ignored. With IDE high, all 29 bits are compared.
- R4: A frame with RTR low, a different IDE, or a different identifier leaves the code and `tx_req` unchanged.
- R5: A grant while `tx_req` is high marks the buffer in flight. `tx_req` falls on the next clock and the code stays 1110.
- R6: A success report while in flight returns the code to 1010 and keeps `tx_req` low. If success and failure arrive in the same cycle, success wins.
- R7: A failure report while in flight keeps the code at 1110 and raises `tx_req` again on the next clock.
- R8: A CPU write of 1110 raises `tx_req` on the next clock. After a successful transmission the code becomes 1010.
- R9: A CPU write of any other value sets the code to that value on the next clock and clears `tx_req` and the in-flight mark. Under any code other than 1010, remote requests cause no change.
- R10: A CPU write takes priority over a match, a grant or a completion in the same cycle.
- R11: A match while the code is 1110, or a completion report while not in flight, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_id | input | 29 | Buffer identifier (standard ID in bits [10:0]) |
| cfg_ide | input | 1 | Buffer uses an extended identifier |
| rx_valid | input | 1 | Received frame qualifier, one cycle per frame |
| rx_id | input | 29 | Received frame identifier |
| rx_ide | input | 1 | Received frame has an extended identifier |
| rx_rtr | input | 1 | Received frame is a remote request |
| arb_grant | input | 1 | Buffer won the current arbitration slot |
| tx_ok | input | 1 | In-flight frame sent successfully |
| tx_fail | input | 1 | In-flight frame lost arbitration or failed |
| cpu_wr | input | 1 | CPU code write strobe |
| cpu_code | input | 4 | Code value written by the CPU |
| code_o | output | 4 | Current code |
| tx_req | output | 1 | Request to join transmit arbitration |

## Verification
The bench sets the buffer's identifier with garbage in the upper bits while in standard mode. A design that compares all 29 bits would then miss a request it must answer. A design that ignores IDE or RTR would answer data frames or frames of the wrong format. The bench sends a failure report between grant and success. A design that drops to 1010 on failure would never retry, and one that keeps `tx_req` high after the grant would ask twice. CPU writes are made to land on a grant, a match and an in-flight frame. A late completion then checks that a cancelled transmission cannot re-arm the buffer or be counted.

// File: rtl/rrq_pkg.sv
package rrq_pkg;
  localparam int CODE_W = 4;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;

  localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_ARMED    = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_SEND     = 4'b1110;
endpackage

// File: rtl/rrq_id_match.sv
// Compares a received remote request with the buffer identifier.
module rrq_id_match #(
  parameter int ID_W  = rrq_pkg::ID_W,
  parameter int STD_W = rrq_pkg::STD_W
) (
  input  logic [ID_W-1:0] cfg_id,
  input  logic            cfg_ide,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  input  logic            rx_ide,
  input  logic            rx_rtr,
  output logic            hit
);
  localparam int EXT_ONLY = ID_W - STD_W;

  logic [ID_W-1:0] bit_eq;
  logic [ID_W-1:0] care;

  // per-bit equality, and which bits matter for the frame format
  for (genvar b = 0; b < ID_W; b++) begin : g_bit
    assign bit_eq[b] = (rx_id[b] == cfg_id[b]);
    if (b < STD_W) begin : g_std
      assign care[b] = 1'b1;
    end else begin : g_ext
      assign care[b] = rx_ide;
    end
  end

  logic id_same;
  assign id_same = &(bit_eq | ~care);

  assign hit = rx_valid && rx_rtr && (rx_ide == cfg_ide) && id_same;

  initial begin
    AST_STD_FITS: assert (EXT_ONLY > 0); // R3
  end
endmodule

// File: rtl/rrq_tx_track.sv
// Tracks whether a granted frame is on the bus and forms the request.
module rrq_tx_track #(
  parameter int CODE_W = rrq_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              arb_grant,
  input  logic              tx_ok,
  input  logic              tx_fail,
  input  logic              cpu_wr,
  output logic              in_flight,
  output logic              done_ok,
  output logic              tx_req
);
  import rrq_pkg::*;

  logic finish;
  assign finish  = in_flight && (tx_ok || tx_fail);
  assign done_ok = in_flight && tx_ok;
  assign tx_req  = (code == CODE_SEND) && !in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  in_flight <= 1'b0;
    else if (cpu_wr)             in_flight <= 1'b0;
    else if (finish)             in_flight <= 1'b0;
    else if (tx_req && arb_grant) in_flight <= 1'b1;
  end

  AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && arb_grant && !cpu_wr) |=> (!tx_req && in_flight)); // R5
  AST_FAIL_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && tx_fail && !tx_ok && !cpu_wr) |=> !in_flight); // R7
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !in_flight); // R9
endmodule

// File: rtl/rrq_code_fsm.sv
// Holds the buffer code and applies CPU writes and automatic updates.
module rrq_code_fsm #(
  parameter int CODE_W = rrq_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CODE_W-1:0] cpu_code,
  input  logic              hit,
  input  logic              done_ok,
  output logic [CODE_W-1:0] code
);
  import rrq_pkg::*;

  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code;
    if (cpu_wr)                               code_nxt = cpu_code;
    else if (code == CODE_SEND && done_ok)    code_nxt = CODE_ARMED;
    else if (code == CODE_ARMED && hit)       code_nxt = CODE_SEND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= CODE_INACTIVE;
    else        code <= code_nxt;
  end

  AST_MATCH_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_ARMED && hit && !cpu_wr) |=> (code == CODE_SEND)); // R2
  AST_OK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_SEND && done_ok && !cpu_wr) |=> (code == CODE_ARMED)); // R6
  AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (code == $past(cpu_code))); // R10
endmodule

// File: rtl/rrq_resp_ctrl.sv
module rrq_resp_ctrl #(
  parameter int ID_W   = rrq_pkg::ID_W,
  parameter int STD_W  = rrq_pkg::STD_W,
  parameter int CODE_W = rrq_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_ide,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ide,
  input  logic              rx_rtr,
  input  logic              arb_grant,
  input  logic              tx_ok,
  input  logic              tx_fail,
  input  logic              cpu_wr,
  input  logic [CODE_W-1:0] cpu_code,
  output logic [CODE_W-1:0] code_o,
  output logic              tx_req
);
  import rrq_pkg::*;

  logic hit;
  logic in_flight;
  logic done_ok;

  rrq_id_match #(.ID_W(ID_W), .STD_W(STD_W)) u_match (
    .cfg_id   (cfg_id),
    .cfg_ide  (cfg_ide),
    .rx_valid (rx_valid),
    .rx_id    (rx_id),
    .rx_ide   (rx_ide),
    .rx_rtr   (rx_rtr),
    .hit      (hit)
  );

  rrq_code_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_code (cpu_code),
    .hit      (hit),
    .done_ok  (done_ok),
    .code     (code_o)
  );

  rrq_tx_track #(.CODE_W(CODE_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code_o),
    .arb_grant (arb_grant),
    .tx_ok     (tx_ok),
    .tx_fail   (tx_fail),
    .cpu_wr    (cpu_wr),
    .in_flight (in_flight),
    .done_ok   (done_ok),
    .tx_req    (tx_req)
  );

  AST_DATA_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == CODE_ARMED && rx_valid && !rx_rtr && !cpu_wr) |=> (code_o == CODE_ARMED)); // R4
  AST_REQ_ONLY_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (code_o == CODE_SEND)); // R9
  AST_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == CODE_INACTIVE && !cpu_wr) |=> (code_o == CODE_INACTIVE && !tx_req)); // R9
  AST_FAIL_KEEPS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && tx_fail && !tx_ok && !cpu_wr) |=> (code_o == CODE_SEND && tx_req)); // R7
endmodule

// File: tb/rrq_resp_ctrl_tb.sv
module rrq_resp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [28:0] cfg_id = 29'h1230_05A3;
  logic        cfg_ide = 1'b0;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0;
  logic        rx_rtr = 1'b0;
  logic        arb_grant = 1'b0;
  logic        tx_ok = 1'b0;
  logic        tx_fail = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [3:0]  cpu_code = '0;
  logic [3:0]  code_o;
  logic        tx_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [3:0] code; logic req; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  rrq_resp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .cfg_ide(cfg_ide),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
    .arb_grant(arb_grant), .tx_ok(tx_ok), .tx_fail(tx_fail),
    .cpu_wr(cpu_wr), .cpu_code(cpu_code), .code_o(code_o), .tx_req(tx_req)
  );

  // monitor: compares registered outputs at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (code_o !== e.code || tx_req !== e.req) begin
        errors++;
        $display("FAIL %s: code=%b tx_req=%b expected code=%b tx_req=%b",
                 e.tag, code_o, tx_req, e.code, e.req);
      end
    end
  end

  task automatic drive(input logic v, input logic [28:0] id, input logic ide,
                       input logic rtr, input logic g, input logic ok,
                       input logic fl, input logic wr, input logic [3:0] wc,
                       input logic [3:0] ec, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    rx_valid = v; rx_id = id; rx_ide = ide; rx_rtr = rtr;
    arb_grant = g; tx_ok = ok; tx_fail = fl; cpu_wr = wr; cpu_code = wc;
    @(posedge clk);
    e.code = ec; e.req = er; e.tag = tag;
    sb.push_back(e);
    #1;
    rx_valid = 0; arb_grant = 0; tx_ok = 0; tx_fail = 0; cpu_wr = 0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    //    v  id             ide rtr g  ok fl wr code      expected
    drive(0, 29'h0,         0, 0, 0, 0, 0, 0, 4'h0,    4'b1000, 0, "R1 reset");
    drive(1, 29'h05A3,      0, 1, 0, 0, 0, 0, 4'h0,    4'b1000, 0, "R9 inactive ignores request");
    drive(0, 29'h0,         0, 0, 0, 0, 0, 1, 4'b1010, 4'b1010, 0, "R9 write armed");
    drive(1, 29'h05A3,      0, 0, 0, 0, 0, 0, 4'h0,    4'b1010, 0, "R4 data frame");
    drive(1, 29'h05A3,      1, 1, 0, 0, 0, 0, 4'h0,    4'b1010, 0, "R4 IDE mismatch");
    drive(1, 29'h05A4,      0, 1, 0, 0, 0, 0, 4'h0,    4'b1010, 0, "R4 ID mismatch");
    drive(1, 29'h0000_05A3, 0, 1, 0, 0, 0, 0, 4'h0,    4'b1110, 1, "R3 std upper bits ignored");
    drive(1, 29'h05A3,      0, 1, 0, 0, 0, 0, 4'h0,    4'b1110, 1, "R11 match in send");
    drive(0, 29'h0,         0, 0, 1, 0, 0, 0, 4'h0,    4'b1110, 0, "R5 grant");
    drive(0, 29'h0,         0, 0, 0, 0, 1, 0, 4'h0,    4'b1110, 1, "R7 fail retry");
    drive(0, 29'h0,         0, 0, 1, 0, 0, 0, 4'h0,    4'b1110, 0, "R5 regrant");
    drive(0, 29'h0,         0, 0, 0, 1, 1, 0, 4'h0,    4'b1010, 0, "R6 success rearms");
    drive(0, 29'h0,         0, 0, 0, 1, 0, 0, 4'h0,    4'b1010, 0, "R11 stray success");
    drive(1, 29'h1FFF_FDA3, 0, 1, 0, 0, 0, 0, 4'h0,    4'b1110, 1, "R2 match again");
    drive(0, 29'h0,         0, 0, 1, 0, 0, 1, 4'b1000, 4'b1000, 0, "R10 write over grant");
    drive(1, 29'h05A3,      0, 1, 0, 0, 0, 0, 4'h0,    4'b1000, 0, "R9 inactive stops matching");
    drive(0, 29'h0,         0, 0, 0, 0, 0, 1, 4'b1110, 4'b1110, 1, "R8 write send");
    drive(0, 29'h0,         0, 0, 1, 0, 0, 0, 4'h0,    4'b1110, 0, "R8 grant");
    drive(0, 29'h0,         0, 0, 0, 0, 0, 1, 4'b1010, 4'b1010, 0, "R9 write cancels in flight");
    drive(0, 29'h0,         0, 0, 0, 1, 0, 0, 4'h0,    4'b1010, 0, "R11 late success after cancel");
    drive(0, 29'h0,         0, 0, 0, 0, 0, 1, 4'b1110, 4'b1110, 1, "R8 write send again");
    drive(0, 29'h0,         0, 0, 1, 0, 0, 0, 4'h0,    4'b1110, 0, "R8 grant again");
    drive(0, 29'h0,         0, 0, 0, 1, 0, 0, 4'h0,    4'b1010, 0, "R8 success returns armed");
    drive(0, 29'h0,         0, 0, 0, 0, 0, 1, 4'b1000, 4'b1000, 0, "R9 park");
    @(negedge clk);
    cfg_id = 29'h1ABC_DEF1; cfg_ide = 1'b1;
    drive(0, 29'h0,         0, 0, 0, 0, 0, 1, 4'b1010, 4'b1010, 0, "R9 arm extended");
    drive(1, 29'h0ABC_DEF1, 1, 1, 0, 0, 0, 0, 4'h0,    4'b1010, 0, "R3 ext bit28 differs");
    drive(1, 29'h1ABC_DEF1, 0, 1, 0, 0, 0, 0, 4'h0,    4'b1010, 0, "R4 ext buffer std frame");
    drive(1, 29'h1ABC_DEF1, 1, 1, 0, 0, 0, 0, 4'h0,    4'b1110, 1, "R3 ext full match");
    drive(0, 29'h0,         0, 0, 1, 0, 0, 0, 4'h0,    4'b1110, 0, "R5 ext grant");
    drive(1, 29'h1ABC_DEF1, 1, 1, 0, 1, 0, 0, 4'h0,    4'b1010, 0, "R11 match during completion");
    drive(1, 29'h1ABC_DEF1, 1, 1, 0, 0, 0, 1, 4'b0100, 4'b0100, 0, "R10 write over match");
    drive(1, 29'h1ABC_DEF1, 1, 1, 0, 0, 0, 0, 4'h0,    4'b0100, 0, "R9 other code holds");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule